// File: doc/BRIEF.md
# Load/Store Data Memory Unit

This block connects a 32-bit processor datapath to a small byte-addressable data memory. For each request it forms an effective address by adding a base register value to a 16-bit signed offset. It then carries out a word, halfword or byte access. On stores, the data is copied into the right byte lanes and only the lanes being addressed are enabled for writing. On loads, the addressed bytes are taken from the registered read word and widened to 32 bits, with sign or zero extension chosen by the operation.

Words are big-endian: byte offset 0 within a word is the most significant byte. A word access with a non-zero two-bit offset is misaligned, and so is a halfword access at an odd address. A misaligned access has no effect on memory, returns no load data, and raises a one-cycle flag instead. The memory holds 256 words and has a synchronous write and a registered read, so load data arrives one cycle after the request.

Top module: `ldst_unit`

## Requirements
- R1: The effective address is `baseVal` plus `immOfs` sign-extended to 32 bits. Bits 9:2 of that sum select one of the 256 memory words, bits 1:0 give the byte offset, and bits 31:10 are ignored.
- R2: `opCode` encodings: 0 word load, 1 signed halfword load, 2 unsigned halfword load, 3 signed byte load, 4 unsigned byte load, 5 word store, 6 halfword store, 7 byte store.
- R3: An accepted load raises `loadValid` for exactly the cycle after the request. In that cycle `loadData` holds the result, and it reflects every store accepted before the load.
- R4: Byte order is big-endian: offset 0 maps to bits 31:24 of a word and offset 3 to bits 7:0. An aligned word load returns the four bytes in that order.
- R5: A signed byte load (3) sign-extends the addressed byte to 32 bits. An unsigned byte load (4) zero-extends it.
- R6: A halfword at offset 0 occupies bits 31:16 of the word and one at offset 2 occupies bits 15:0. Load 1 sign-extends the halfword and load 2 zero-extends it.
- R7: A byte store writes only the addressed byte, using `storeVal[7:0]`. A halfword store writes only the two addressed bytes, using `storeVal[15:0]`. A word store writes all four bytes.
- R8: A word access is misaligned when address bits 1:0 are not 00. A halfword access is misaligned when bit 0 is 1. Byte accesses are never misaligned. A misaligned request sets `misalign` for exactly the following cycle and leaves `loadValid` low.
- R9: A misaligned store leaves memory contents unchanged.
- R10: While `reqValid` is low, nothing is written, and `loadValid` and `misalign` stay low in the following cycle.
- R11: During and right after reset, `loadValid` and `misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| opCode | input | 3 | Operation select (R2) |
| baseVal | input | 32 | Base register value |
| immOfs | input | 16 | Signed address offset |
| storeVal | input | 32 | Store data (rt register value) |
| loadData | output | 32 | Extended load result |
| loadValid | output | 1 | Load result present |
| misalign | output | 1 | Previous request was misaligned |

## Verification
Stores take effect at the clock edge where the request is sampled. Load data, `loadValid` and `misalign` all appear in the single cycle after that edge. The bench drives each request on a falling edge and samples the outputs shortly after the next rising edge. There it compares them with a byte-level reference model that has already applied every earlier accepted store. Requests are issued back to back, so a store followed directly by a load of the same location checks the next-cycle visibility of written data. Idle cycles check that both flags fall after one cycle.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    OP_LDW  = 3'd0,
    OP_LDH  = 3'd1,
    OP_LDHU = 3'd2,
    OP_LDB  = 3'd3,
    OP_LDBU = 3'd4,
    OP_STW  = 3'd5,
    OP_STH  = 3'd6,
    OP_STB  = 3'd7
  } ldstOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [LANES-1:0] byteEn;
    accSize_e         size;
    logic             signExt;
  } ctrlStrb_t;
endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] opCode,
  input  logic [1:0] addrLow,
  output ctrlStrb_t  strb,
  output logic       loadValid,
  output logic       misalign
);
  ldstOp_e  op;
  accSize_e size;
  logic     isLoad;
  logic     signExt;
  logic     aligned;
  logic     accept;
  logic [LANES-1:0] laneHit;

  assign op = ldstOp_e'(opCode);

  always_comb begin
    isLoad  = 1'b0;
    signExt = 1'b0;
    size    = SZ_WORD;
    unique case (op)
      OP_LDW:  begin isLoad = 1'b1; size = SZ_WORD; end
      OP_LDH:  begin isLoad = 1'b1; size = SZ_HALF; signExt = 1'b1; end
      OP_LDHU: begin isLoad = 1'b1; size = SZ_HALF; end
      OP_LDB:  begin isLoad = 1'b1; size = SZ_BYTE; signExt = 1'b1; end
      OP_LDBU: begin isLoad = 1'b1; size = SZ_BYTE; end
      OP_STW:  size = SZ_WORD;
      OP_STH:  size = SZ_HALF;
      OP_STB:  size = SZ_BYTE;
      default: size = SZ_WORD;
    endcase
  end

  always_comb begin
    unique case (size)
      SZ_WORD: aligned = (addrLow == 2'b00);
      SZ_HALF: aligned = ~addrLow[0];
      default: aligned = 1'b1;
    endcase
  end

  assign accept = reqValid && aligned;

  // Lane l carries bits 8l+7:8l; big-endian offset o lands in lane LANES-1-o.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: laneHit[l] = (2'(LANES - 1 - l) == addrLow);
        SZ_HALF: laneHit[l] = (l / 2 == 1) ? ~addrLow[1] : addrLow[1];
        default: laneHit[l] = 1'b1;
      endcase
    end
  end

  always_comb begin
    strb.wrEn    = accept && !isLoad;
    strb.rdEn    = accept && isLoad;
    strb.byteEn  = laneHit;
    strb.size    = size;
    strb.signExt = signExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      misalign  <= 1'b0;
    end else begin
      loadValid <= strb.rdEn;
      misalign  <= reqValid && !aligned;
    end
  end
endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
#(
  parameter int MEM_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [15:0]       immOfs,
  input  logic [DATA_W-1:0] storeVal,
  output logic [1:0]        addrLow,
  output logic [DATA_W-1:0] loadData
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  logic [DATA_W-1:0] sextImm;
  logic [DATA_W-1:0] effAddr;
  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] laneData;
  logic              unusedAddrHi;

  logic [DATA_W-1:0] memArr [MEM_WORDS];
  logic [DATA_W-1:0] rdWord;
  logic [1:0]        rspOfs;
  accSize_e          rspSize;
  logic              rspSign;

  assign sextImm      = {{(DATA_W-16){immOfs[15]}}, immOfs};
  assign effAddr      = baseVal + sextImm;
  assign addrLow      = effAddr[1:0];
  assign wordIdx      = effAddr[IDX_W+1:2];
  assign unusedAddrHi = ^effAddr[DATA_W-1:IDX_W+2];

  always_comb begin
    unique case (strb.size)
      SZ_BYTE: laneData = {LANES{storeVal[7:0]}};
      SZ_HALF: laneData = {(LANES/2){storeVal[15:0]}};
      default: laneData = storeVal;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_wr
    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.byteEn[l])
        memArr[wordIdx][8*l +: 8] <= laneData[8*l +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.rdEn) rdWord <= memArr[wordIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspOfs  <= 2'b00;
      rspSize <= SZ_WORD;
      rspSign <= 1'b0;
    end else if (strb.rdEn) begin
      rspOfs  <= effAddr[1:0];
      rspSize <= strb.size;
      rspSign <= strb.signExt;
    end
  end

  logic [7:0]  pickByte;
  logic [15:0] pickHalf;

  always_comb begin
    pickByte = rdWord[8*(LANES-1-32'(rspOfs)) +: 8];
    pickHalf = rspOfs[1] ? rdWord[15:0] : rdWord[31:16];
    unique case (rspSize)
      SZ_BYTE: loadData = {{(DATA_W-8){rspSign & pickByte[7]}}, pickByte};
      SZ_HALF: loadData = {{(DATA_W-16){rspSign & pickHalf[15]}}, pickHalf};
      default: loadData = rdWord;
    endcase
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int MEM_WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  opCode,
  input  logic [31:0] baseVal,
  input  logic [15:0] immOfs,
  input  logic [31:0] storeVal,
  output logic [31:0] loadData,
  output logic        loadValid,
  output logic        misalign
);
  ctrlStrb_t  strb;
  logic [1:0] addrLow;

  ldst_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .opCode   (opCode),
    .addrLow  (addrLow),
    .strb     (strb),
    .loadValid(loadValid),
    .misalign (misalign)
  );

  ldst_datapath #(.MEM_WORDS(MEM_WORDS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .baseVal (baseVal),
    .immOfs  (immOfs),
    .storeVal(storeVal),
    .addrLow (addrLow),
    .loadData(loadData)
  );
endmodule

// File: rtl/ldst_checker.sv
module ldst_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [2:0]  opCode,
  input logic [31:0] baseVal,
  input logic [15:0] immOfs,
  input logic [31:0] storeVal,
  input logic [31:0] loadData,
  input logic        loadValid,
  input logic        misalign
);
  AST_LOAD_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> ($past(reqValid) && $past(opCode) <= 3'd4)); // R3

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(loadValid && misalign)); // R8

  AST_MIS_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> ($past(reqValid) && !($past(opCode) inside {3'd3, 3'd4, 3'd7}))); // R8

  AST_BYTE_NEVER_MIS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opCode inside {3'd3, 3'd4, 3'd7}) |=> !misalign); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!loadValid && !misalign)); // R10

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && $past(opCode) == 3'd4) |-> (loadData[31:8] == 24'd0)); // R5

  AST_BYTE_SEXT: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && $past(opCode) == 3'd3) |-> (loadData[31:8] == {24{loadData[7]}})); // R5

  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && $past(opCode) == 3'd2) |-> (loadData[31:16] == 16'd0)); // R6

  AST_HALF_SEXT: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && $past(opCode) == 3'd1) |-> (loadData[31:16] == {16{loadData[15]}})); // R6

  logic unusedChk;
  assign unusedChk = ^{baseVal, immOfs, storeVal};
endmodule

bind ldst_unit ldst_checker u_chk (.*);

// File: tb/sim_ldst_unit.sv
`timescale 1ns/1ps
module sim_ldst_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  opCode;
  logic [31:0] baseVal;
  logic [15:0] immOfs;
  logic [31:0] storeVal;
  logic [31:0] loadData;
  logic        loadValid;
  logic        misalign;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] refMem [0:1023];

  always #2.5 clk = ~clk;

  ldst_unit u0 (.*);

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: expired, actual=hung expected=done");
    report();
  end

  function automatic logic [31:0] refLoad(input logic [2:0] op, input logic [9:0] a);
    logic [9:0] w = {a[9:2], 2'b00};
    logic [9:0] h = {a[9:1], 1'b0};
    logic [15:0] hv = {refMem[h], refMem[h + 10'd1]};
    logic [7:0] bv = refMem[a];
    case (op)
      3'd0: return {refMem[w], refMem[w+10'd1], refMem[w+10'd2], refMem[w+10'd3]};
      3'd1: return {{16{hv[15]}}, hv};
      3'd2: return {16'd0, hv};
      3'd3: return {{24{bv[7]}}, bv};
      default: return {24'd0, bv};
    endcase
  endfunction

  task automatic doOp(input logic [2:0] op, input logic [31:0] b, input logic [15:0] imm,
                      input logic [31:0] d, input string tag, input bit vld = 1'b1);
    logic [31:0] a;
    logic [9:0]  ba;
    bit          al;
    bit          isLd;
    bit          eV, eM;
    logic [31:0] eD;
    @(negedge clk);
    reqValid = vld; opCode = op; baseVal = b; immOfs = imm; storeVal = d;
    a    = b + {{16{imm[15]}}, imm};
    ba   = a[9:0];
    isLd = (op <= 3'd4);
    al   = (op == 3'd0 || op == 3'd5) ? (a[1:0] == 2'b00) :
           (op inside {3'd1, 3'd2, 3'd6}) ? !a[0] : 1'b1;
    eV = vld && al && isLd;
    eM = vld && !al;
    eD = eV ? refLoad(op, ba) : 32'd0;
    if (vld && al && !isLd) begin
      case (op)
        3'd5: for (int i = 0; i < 4; i++) refMem[{ba[9:2], 2'(i)}] = d[8*(3-i) +: 8];
        3'd6: begin refMem[{ba[9:1], 1'b0}] = d[15:8]; refMem[{ba[9:1], 1'b1}] = d[7:0]; end
        default: refMem[ba] = d[7:0];
      endcase
    end
    @(posedge clk);
    #1;
    testsRun++;
    if (loadValid !== eV || misalign !== eM || (eV && loadData !== eD)) begin
      testsFailed++;
      $display("FAIL %s: actual v=%0b m=%0b d=%h expected v=%0b m=%0b d=%h",
               tag, loadValid, misalign, loadData, eV, eM, eD);
    end
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; opCode = 3'd0;
    baseVal = 32'd0; immOfs = 16'd0; storeVal = 32'd0;
    for (int i = 0; i < 1024; i++) refMem[i] = 8'd0;
    repeat (3) @(posedge clk);
    #1;
    testsRun++;
    if (loadValid !== 1'b0 || misalign !== 1'b0) begin
      testsFailed++;
      $display("FAIL R11: actual v=%0b m=%0b expected v=0 m=0", loadValid, misalign);
    end
    @(negedge clk); rstN = 1'b1;
    // R11 right after reset
    doOp(3'd0, 32'd0, 16'd0, 32'd0, "R11", 1'b0);

    // fill memory with word stores (R7)
    for (int i = 0; i < 256; i++)
      doOp(3'd5, 32'(i * 4), 16'd0, 32'h1000_0000 ^ (32'(i) * 32'h0101_0101), "R7");

    // R4 big-endian word round trip, back-to-back store then load
    doOp(3'd5, 32'h40, 16'd0, 32'h8123_45F6, "R4");
    doOp(3'd0, 32'h40, 16'd0, 32'd0, "R3");
    doOp(3'd3, 32'h40, 16'd0, 32'd0, "R4");
    doOp(3'd4, 32'h40, 16'd3, 32'd0, "R4");
    // R5 byte sign / zero extension
    doOp(3'd3, 32'h40, 16'd3, 32'd0, "R5");
    doOp(3'd4, 32'h40, 16'd0, 32'd0, "R5");
    doOp(3'd3, 32'h40, 16'd1, 32'd0, "R5");
    // R6 halfword lanes and extension
    doOp(3'd1, 32'h40, 16'd0, 32'd0, "R6");
    doOp(3'd2, 32'h40, 16'd0, 32'd0, "R6");
    doOp(3'd1, 32'h40, 16'd2, 32'd0, "R6");
    doOp(3'd2, 32'h40, 16'd2, 32'd0, "R6");
    // R7 byte and halfword stores touch only their lanes
    doOp(3'd7, 32'h80, 16'd2, 32'hDEAD_BEEF, "R7");
    doOp(3'd0, 32'h80, 16'd0, 32'd0, "R7");
    doOp(3'd6, 32'h84, 16'd2, 32'hCAFE_9A5C, "R7");
    doOp(3'd0, 32'h84, 16'd0, 32'd0, "R7");
    doOp(3'd6, 32'h88, 16'd0, 32'h0000_7FFE, "R7");
    doOp(3'd1, 32'h88, 16'd0, 32'd0, "R7");
    // R1 negative offset, high address bits ignored
    doOp(3'd5, 32'h0000_0110, 16'hFFF0, 32'hA5A5_0F0F, "R1");
    doOp(3'd0, 32'hFFFF_F100, 16'd0, 32'd0, "R1");
    doOp(3'd4, 32'h0000_0104, 16'hFFFD, 32'd0, "R1");
    // R8 misaligned loads
    doOp(3'd0, 32'h40, 16'd2, 32'd0, "R8");
    doOp(3'd0, 32'h40, 16'd1, 32'd0, "R8");
    doOp(3'd1, 32'h40, 16'd1, 32'd0, "R8");
    doOp(3'd2, 32'h40, 16'd3, 32'd0, "R8");
    doOp(3'd0, 32'd0, 16'd0, 32'd0, "R8", 1'b0);
    // R9 misaligned stores leave memory alone
    doOp(3'd5, 32'hC0, 16'd1, 32'hFFFF_FFFF, "R9");
    doOp(3'd6, 32'hC4, 16'd3, 32'hFFFF_FFFF, "R9");
    doOp(3'd0, 32'hC0, 16'd0, 32'd0, "R9");
    doOp(3'd0, 32'hC4, 16'd0, 32'd0, "R9");
    // R10 idle request with store op writes nothing
    doOp(3'd5, 32'hC8, 16'd0, 32'h1234_5678, "R10", 1'b0);
    doOp(3'd7, 32'hC8, 16'd1, 32'h0000_00AA, "R10", 1'b0);
    doOp(3'd0, 32'hC8, 16'd0, 32'd0, "R10");
    // R2 every opcode at one location
    for (int op = 0; op < 8; op++)
      doOp(3'(op), 32'h100, 16'(op & 2), 32'h9E8D_7C6B, "R2");
    doOp(3'd0, 32'h100, 16'd0, 32'd0, "R2");
    doOp(3'd0, 32'd0, 16'd0, 32'd0, "R10", 1'b0);
    report();
  end
endmodule